// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block generates one pulse-width-modulated output from a host-programmed register set. An up-counter advances once per 2^N input clocks, where N is a 3-bit power-of-two prescaler select. It runs from zero up to a programmed wrap value and then restarts at zero. The output is active while the count is above a programmed threshold, and an optional polarity bit inverts the waveform.

The host programs the block in a fixed sequence:
1. Choose the prescaler and polarity while the timer is disabled.
2. Enable the timer.
3. Write the wrap and threshold values.
4. Wait for their write-complete flags and clear them.
5. Set the start bit.

Each register accepts writes only in the phase meant for it; a write in the wrong phase is dropped. A new wrap or threshold value written while the counter runs waits in a holding register and takes effect at the next wrap, so a period is never cut short or torn.

Register offsets (word addresses) are:

| Offset | Register |
|--------|----------|
| 0 | status |
| 1 | flag-clear |
| 2 | setup |
| 3 | control |
| 4 | threshold |
| 5 | wrap |

Top module: `lpwm_timer`

## Requirements
- R1: After reset the following all read 0 and `pwm_out` is 0: every register (status at 0, flag-clear at 1, setup at 2, control at 3, threshold at 4, wrap at 5).
- R2: Setup (bits [2:0] prescaler select N, bit 3 polarity) is written only while control bit 0 (enable) reads 0. A setup write while enabled is ignored and the old value reads back.
- R3: Threshold and wrap writes are accepted only while enabled. Writes while disabled are dropped, the old value reads back, and no status flag is raised.
- R4: Once started, the count after clock j (counted from the start write) is floor(j / 2^N) mod (wrap+1). This holds up to the largest divide of 128 (N=7), and the prescaler phase restarts at the start write.
- R5: While started, the output is active when count > threshold and inactive otherwise. With polarity 1 the output is inverted: the inactive level is 1 and the active level is 0.
- R6: A control write with bit 0 and bit 2 both set starts continuous counting only if the timer was already enabled. From the disabled state such a write only enables. Control reads back bit 0 = enable and bit 2 = started.
- R7: An accepted threshold write sets status bit 0, and an accepted wrap write sets status bit 1. The bit is set exactly two prescaled ticks after the write; with N=0 it is visible on the second clock after the write edge.
- R8: Writing 1 to a flag-clear bit (bit 0 threshold, bit 1 wrap) clears the matching status bit. Bits written as 0 leave their flag unchanged.
- R9: A threshold or wrap value written while counting takes effect at the next wrap of the counter, not before. Before the start, it takes effect at once.
- R10: A control write with bit 0 = 0 does the following at once: stops counting, resets count and prescaler to 0, clears the start state, and drives the output to its inactive level. It keeps the wrap and threshold values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest case to reach is a threshold change that lands mid-period while the counter runs. It must not affect the waveform until the counter next wraps. The stimulus starts the counter, pushes the full expected waveform into the scoreboard, and then issues the threshold write at a fixed clock inside the second period. The expected waveform switches thresholds exactly at the third period, so an early update shows up as a mismatched cycle. The largest divide (N=7) is also run long enough to see two full prescaled periods and the delayed write-complete flags.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;

  localparam int ADDR_W = 3;

  // register word offsets
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FCLR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SETUP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_THRESH = 3'd4;
  localparam logic [ADDR_W-1:0] A_WRAP   = 3'd5;

  // control bit positions
  localparam int CTRL_EN = 0;
  localparam int CTRL_GO = 2;

  // status / clear bit positions, also tracker indices
  localparam int FLG_THR  = 0;
  localparam int FLG_WRAP = 1;
  localparam int N_FLG    = 2;

  // write-to-complete latency in prescaled ticks
  localparam int DONE_LAT = 2;

endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [N_FLG-1:0]  done,
  output logic              en_q,
  output logic              go_q,
  output logic [PSC_W-1:0]  psc_q,
  output logic              pol_q,
  output logic [CNT_W-1:0]  wrap_sh,
  output logic [CNT_W-1:0]  thr_sh,
  output logic [N_FLG-1:0]  arm,
  output logic              start_p,
  output logic              stop_p,
  output logic [CNT_W-1:0]  rdata
);

  logic             en_d, go_d, pol_d;
  logic [PSC_W-1:0] psc_d;
  logic [CNT_W-1:0] wrap_d, thr_d;
  logic [N_FLG-1:0] flg_q, flg_d, clr;
  logic             wr_ctrl, wr_setup, wr_fclr;

  always_comb begin
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_setup = wr_en && (addr == A_SETUP) && !en_q;
    wr_fclr  = wr_en && (addr == A_FCLR);
    arm[FLG_THR]  = wr_en && (addr == A_THRESH) && en_q;
    arm[FLG_WRAP] = wr_en && (addr == A_WRAP) && en_q;
    start_p  = wr_ctrl && wdata[CTRL_EN] && wdata[CTRL_GO] && en_q && !go_q;
    stop_p   = wr_ctrl && !wdata[CTRL_EN];
    clr      = wr_fclr ? wdata[N_FLG-1:0] : '0;
  end

  always_comb begin
    en_d   = en_q;
    go_d   = go_q;
    psc_d  = psc_q;
    pol_d  = pol_q;
    wrap_d = wrap_sh;
    thr_d  = thr_sh;
    if (wr_ctrl) begin
      en_d = wdata[CTRL_EN];
      go_d = wdata[CTRL_EN] && (go_q || (wdata[CTRL_GO] && en_q));
    end
    if (wr_setup) begin
      psc_d = wdata[PSC_W-1:0];
      pol_d = wdata[PSC_W];
    end
    if (arm[FLG_THR])  thr_d  = wdata;
    if (arm[FLG_WRAP]) wrap_d = wdata;
    // a completion in the same cycle as a clear wins
    flg_d = (flg_q & ~clr) | done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      go_q    <= 1'b0;
      psc_q   <= '0;
      pol_q   <= 1'b0;
      wrap_sh <= '0;
      thr_sh  <= '0;
      flg_q   <= '0;
    end else begin
      en_q    <= en_d;
      go_q    <= go_d;
      psc_q   <= psc_d;
      pol_q   <= pol_d;
      wrap_sh <= wrap_d;
      thr_sh  <= thr_d;
      flg_q   <= flg_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_STAT:   rdata[N_FLG-1:0] = flg_q;
      A_SETUP:  rdata[PSC_W:0]   = {pol_q, psc_q};
      A_CTRL: begin
        rdata[CTRL_EN] = en_q;
        rdata[CTRL_GO] = go_q;
      end
      A_THRESH: rdata = thr_sh;
      A_WRAP:   rdata = wrap_sh;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/lpwm_prescaler.sv
module lpwm_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  localparam int PRE_W = (1 << PSC_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(psc));
    end
  end

  always_comb begin
    if (!en || sync_clr) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
    tick = en && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/lpwm_wr_track.sv
module lpwm_wr_track #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  input  logic clr,
  output logic done
);

  localparam int W = $clog2(LAT + 1);
  localparam logic [W-1:0] LAT_V = W'(LAT);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (clr)                          left_d = '0;
    else if (arm)                     left_d = LAT_V;
    else if (tick && left_q != '0)    left_d = left_q - 1'b1;
    done = tick && (left_q == ONE_V) && !arm && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

endmodule

// File: rtl/lpwm_counter.sv
module lpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic             clr,
  input  logic             pol,
  input  logic [CNT_W-1:0] wrap_sh,
  input  logic [CNT_W-1:0] thr_sh,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] wrap_act,
  output logic [CNT_W-1:0] thr_act,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cnt_d, wrap_d, thr_d;
  logic             at_top, load;

  always_comb begin
    at_top = (cnt_q == wrap_act);
    load   = !go || (tick && at_top);
    if (clr || !go)  cnt_d = '0;
    else if (tick)   cnt_d = at_top ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    wrap_d = load ? wrap_sh : wrap_act;
    thr_d  = load ? thr_sh  : thr_act;
    pwm_out = pol ^ (go && (cnt_q > thr_act));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      wrap_act <= '0;
      thr_act  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      wrap_act <= wrap_d;
      thr_act  <= thr_d;
    end
  end

endmodule

// File: rtl/lpwm_timer.sv
module lpwm_timer
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pwm_out
);

  logic             rst_m_n, rst_s_n;
  logic             en_q, go_q, pol_q, start_p, stop_p, tick;
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W:0]   cfg_q;
  logic [CNT_W-1:0] wrap_sh, thr_sh, cnt_q, wrap_act, thr_act;
  logic [N_FLG-1:0] arm, done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  assign cfg_q = {pol_q, psc_q};

  lpwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .done(done), .en_q(en_q), .go_q(go_q), .psc_q(psc_q), .pol_q(pol_q),
    .wrap_sh(wrap_sh), .thr_sh(thr_sh), .arm(arm), .start_p(start_p),
    .stop_p(stop_p), .rdata(rdata)
  );

  lpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_s_n), .en(en_q), .sync_clr(start_p | stop_p),
    .psc(psc_q), .tick(tick)
  );

  for (genvar g = 0; g < N_FLG; g++) begin : g_trk
    lpwm_wr_track #(.LAT(DONE_LAT)) u_trk (
      .clk(clk), .rst_n(rst_s_n), .arm(arm[g]), .tick(tick),
      .clr(stop_p), .done(done[g])
    );
  end

  lpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .go(go_q), .tick(tick), .clr(stop_p),
    .pol(pol_q), .wrap_sh(wrap_sh), .thr_sh(thr_sh), .cnt_q(cnt_q),
    .wrap_act(wrap_act), .thr_act(thr_act), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/lpwm_timer_chk.sv
module lpwm_timer_chk
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              en_q,
  input logic              go_q,
  input logic [PSC_W:0]    cfg_q,
  input logic [CNT_W-1:0]  wrap_sh,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  wrap_act,
  input logic              pwm_out
);

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_en && addr == A_SETUP) |=> $stable(cfg_q));

  // R3
  reload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && wr_en && addr == A_WRAP) |=> $stable(wrap_sh));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (cnt_q <= wrap_act));

  // R6
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> ($past(en_q) && cnt_q == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |-> (cnt_q == '0));

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |-> (pwm_out == cfg_q[PSC_W]));

endmodule

bind lpwm_timer lpwm_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .en_q(en_q),
  .go_q(go_q), .cfg_q(cfg_q), .wrap_sh(wrap_sh), .cnt_q(cnt_q),
  .wrap_act(wrap_act), .pwm_out(pwm_out)
);

// File: tb/lpwm_timer_bench.sv
`timescale 1ns/1ps
module lpwm_timer_bench;

  localparam int CW = 16;

  logic          clk, rst_n, wr_en;
  logic [2:0]    addr;
  logic [CW-1:0] wdata;
  logic [CW-1:0] rdata;
  logic          pwm_out;

  int    n_chk, n_fail;
  string run_tag;

  typedef struct { bit val; int idx; } exp_t;
  exp_t exp_q[$];

  lpwm_timer u_lpwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: one expected output bit per clock
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(pwm_out === e.val, run_tag, int'(pwm_out), int'(e.val));
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == CW'(exp), req, int'(rdata), exp);
  endtask

  // driver: queue the expected waveform, then issue the start write
  task automatic start_run(input int wrapv, input int thr_a, input int thr_b,
                           input int sw_j, input int p, input int pol,
                           input int n, input string tag);
    @(negedge clk);
    run_tag = tag;
    for (int j = 0; j < n; j++) begin
      int c;
      int t;
      exp_t e;
      c = (j >> p) % (wrapv + 1);
      t = (j < sw_j) ? thr_a : thr_b;
      e.val = pol[0] ^ (c > t);
      e.idx = j;
      exp_q.push_back(e);
    end
    wr_en = 1'b1; addr = 3'd3; wdata = CW'(5);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; run_tag = "";
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 0, "R1");
    chk(pwm_out == 1'b0, "R1 pwm", int'(pwm_out), 0);

    // R3 threshold write while disabled is dropped
    wr(3'd4, 7);
    repeat (4) @(negedge clk);
    rd(3'd4, 0, "R3 thresh");
    rd(3'd0, 0, "R3 no flag");

    // enable, then R2 setup write is ignored
    wr(3'd3, 1);
    rd(3'd3, 1, "R6 enabled");
    wr(3'd2, 11);
    rd(3'd2, 0, "R2 locked");

    // R7 exact flag latency with N=0
    wr(3'd4, 6);
    rd(3'd0, 0, "R7 early");
    rd(3'd0, 1, "R7 done");
    wr(3'd5, 9);
    repeat (3) @(negedge clk);
    rd(3'd0, 3, "R7 both");
    rd(3'd4, 6, "R3 thresh accepted");

    // R8 clear one flag at a time
    wr(3'd1, 1);
    rd(3'd0, 2, "R8 clear thr");
    wr(3'd1, 0);
    rd(3'd0, 2, "R8 zero no effect");
    wr(3'd1, 2);
    rd(3'd0, 0, "R8 clear wrap");

    // R4/R5/R9 run, threshold changes mid second period
    start_run(9, 6, 2, 20, 0, 0, 30, "R9 wrap-aligned update");
    repeat (11) @(negedge clk);
    wr(3'd4, 2);
    wait (exp_q.size() == 0);
    rd(3'd3, 5, "R6 running");

    // R10 disable keeps values, stops output
    wr(3'd3, 0);
    #1;
    chk(pwm_out == 1'b0, "R10 inactive", int'(pwm_out), 0);
    rd(3'd3, 0, "R10 ctrl");
    rd(3'd4, 2, "R10 keep thresh");
    rd(3'd5, 9, "R10 keep wrap");

    // R2 accepted while disabled: polarity 1, N=1
    wr(3'd2, 9);
    rd(3'd2, 9, "R2 accepted");
    chk(pwm_out == 1'b1, "R5 inverted idle", int'(pwm_out), 1);

    // R6 start bit from disabled only enables
    wr(3'd3, 5);
    rd(3'd3, 1, "R6 no start");
    wr(3'd5, 3);
    wr(3'd4, 1);
    repeat (8) @(negedge clk);
    start_run(3, 1, 1, 1000, 1, 1, 16, "R5 inverted run");
    wait (exp_q.size() == 0);

    // R4 largest divide
    wr(3'd3, 0);
    wr(3'd1, 3);
    wr(3'd2, 7);
    wr(3'd3, 1);
    wr(3'd5, 1);
    wr(3'd4, 0);
    repeat (400) @(negedge clk);
    rd(3'd0, 3, "R7 divide 128");
    start_run(1, 0, 0, 100000, 7, 0, 600, "R4 divide 128");
    wait (exp_q.size() == 0);

    finish_run();
  end

endmodule